// File: doc/BRIEF.md
# Two-Port Memory with Collision Arbitration

A synchronous static memory with two identical ports, left and right. Each port has its own enable, write select, output enable, address, write data and read data, so the two sides can read and write independently. When both ports are enabled on the same word and at least one of them writes, a compare-and-grant stage gives the word to one port and raises a busy flag toward the other. A write from the blocked side is not lost. It is parked in a one-entry holding register and lands in the array once busy clears.

A mode strap picks where busy comes from. With `master_i` high, busy is generated from the internal address compare. With `master_i` low, each port's busy is taken from its `*_busy_i` input and the internal compare is not used. This lets several devices share one arbiter when they are placed side by side to widen the word. The default `ADDR_W` of 8 keeps elaboration small. `ADDR_W = 13` with `DATA_W = 9` gives the full 8192 x 9 organisation.

Top module: `twin_port_ram`

## Requirements
- R1: The array holds 2**ADDR_W words of DATA_W bits. A write from an unblocked port is stored at the clock edge. A read (en=1, we=0) returns the word one clock after the address is sampled. After reset both read outputs and both busy outputs are 0.
- R2: In master mode a collision exists when both ports are enabled, their addresses are equal and at least one of them writes. The port whose address was already present in the previous cycle wins, and busy is raised only to the other port. Busy stays with that port for as long as the collision lasts.
- R3: In master mode, if neither port held the colliding address in the previous cycle, or both did, the left port wins and `r_busy_o` is raised.
- R4: Busy is computed from the current cycle's inputs. It drops in the same cycle the addresses stop matching or the winner is disabled.
- R5: A write issued while its port is busy leaves the array unchanged and is kept in a one-entry pending register. A later blocked write replaces the pending one. The pending write is committed in the first cycle in which the port is not busy.
- R6: In slave mode (`master_i`=0), each `*_busy_o` follows its `*_busy_i` input, and address matches raise no busy. If both ports write the same word in the same cycle, the left data is kept.
- R7: Two reads of the same word never raise busy in master mode.
- R8: With `*_oe_i` low, that port's read output is 0. The held read word reappears when oe returns high.
- R9: A read of the word being written in the same cycle returns the old contents. The new contents are returned by the next read.
- R10: Both ports behave the same way: the right port wins and `l_busy_o` is raised when the right port presented the address first.
- R11: When a pending write commits in the same cycle that the port issues a new unblocked write, the pending word is written first and the new write is committed one cycle later. Neither write is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| master_i | input | 1 | 1: busy from internal compare; 0: busy from `*_busy_i` |
| l_en_i | input | 1 | Left port enable |
| l_we_i | input | 1 | Left write (1) or read (0) |
| l_oe_i | input | 1 | Left read output enable |
| l_addr_i | input | ADDR_W | Left address |
| l_wdata_i | input | DATA_W | Left write data |
| l_busy_i | input | 1 | Left busy input, used in slave mode |
| l_rdata_o | output | DATA_W | Left read data |
| l_busy_o | output | 1 | Left port is blocked |
| r_en_i | input | 1 | Right port enable |
| r_we_i | input | 1 | Right write (1) or read (0) |
| r_oe_i | input | 1 | Right read output enable |
| r_addr_i | input | ADDR_W | Right address |
| r_wdata_i | input | DATA_W | Right write data |
| r_busy_i | input | 1 | Right busy input, used in slave mode |
| r_rdata_o | output | DATA_W | Right read data |
| r_busy_o | output | 1 | Right port is blocked |

## Verification
The bench targets who wins a collision: a same-cycle tie, left arriving first and right arriving first. An arbiter that ignored arrival order would block the wrong side, and one that re-decided every cycle would let busy swap sides in the middle of a collision. It holds a blocked write across several cycles with changing data and then reads the word back. A design that dropped the parked write, or applied it while still blocked, returns the wrong word. It also checks read-before-write on a colliding read, the back-to-back drain of a pending write followed by a new one, and slave mode, where a design that still used its own compare would raise busy or block writes that the external input allows.

// File: rtl/twin_port_ram_pkg.sv
package twin_port_ram_pkg;
  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_e;
endpackage

// File: rtl/twin_port_ram_arb.sv
module twin_port_ram_arb
  import twin_port_ram_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              master_i,
  input  logic              l_en_i,
  input  logic              l_we_i,
  input  logic [ADDR_W-1:0] l_addr_i,
  input  logic              l_busy_ext_i,
  input  logic              r_en_i,
  input  logic              r_we_i,
  input  logic [ADDR_W-1:0] r_addr_i,
  input  logic              r_busy_ext_i,
  output logic              l_blk_o,
  output logic              r_blk_o
);
  owner_e            owner_q, win;
  logic              l_prev_en_q, r_prev_en_q;
  logic [ADDR_W-1:0] l_prev_addr_q, r_prev_addr_q;
  logic              coll, l_old, r_old;

  always_comb begin
    coll  = l_en_i && r_en_i && (l_addr_i == r_addr_i) && (l_we_i || r_we_i);
    l_old = l_prev_en_q && (l_prev_addr_q == l_addr_i);
    r_old = r_prev_en_q && (r_prev_addr_q == r_addr_i);
    if (!coll)                 win = OWN_NONE;
    else if (owner_q != OWN_NONE) win = owner_q;
    else if (r_old && !l_old)  win = OWN_RIGHT;  // right arrived first
    else                       win = OWN_LEFT;   // left first or tie
    l_blk_o = master_i ? (win == OWN_RIGHT) : l_busy_ext_i;
    r_blk_o = master_i ? (win == OWN_LEFT)  : r_busy_ext_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      owner_q       <= OWN_NONE;
      l_prev_en_q   <= 1'b0;
      r_prev_en_q   <= 1'b0;
      l_prev_addr_q <= '0;
      r_prev_addr_q <= '0;
    end else begin
      owner_q       <= master_i ? win : OWN_NONE;
      l_prev_en_q   <= l_en_i;
      r_prev_en_q   <= r_en_i;
      l_prev_addr_q <= l_addr_i;
      r_prev_addr_q <= r_addr_i;
    end
  end

  AST_ONE_LOSER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    master_i |-> !(l_blk_o && r_blk_o)); // R2
  AST_HOLD_LOSER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_i && $past(master_i) && $past(r_blk_o) && l_en_i && r_en_i
     && (l_addr_i == r_addr_i) && (l_we_i || r_we_i)) |-> r_blk_o); // R2
  AST_NEW_RIGHT_LOSES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_i && !$past(r_en_i)) |-> !l_blk_o); // R3
  AST_READS_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_i && !l_we_i && !r_we_i) |-> !(l_blk_o || r_blk_o)); // R7
endmodule

// File: rtl/twin_port_ram_wq.sv
module twin_port_ram_wq #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              blk_i,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_data_o
);
  logic              pend_v_q;
  logic [ADDR_W-1:0] pend_addr_q;
  logic [DATA_W-1:0] pend_data_q;
  logic              wr_req;

  always_comb begin
    wr_req     = en_i && we_i;
    mem_we_o   = 1'b0;
    mem_addr_o = pend_addr_q;
    mem_data_o = pend_data_q;
    if (!blk_i) begin
      if (pend_v_q) begin
        mem_we_o = 1'b1;
      end else if (wr_req) begin
        mem_we_o   = 1'b1;
        mem_addr_o = addr_i;
        mem_data_o = wdata_i;
      end
    end
  end

  // park a write that is blocked or that queues behind a draining one
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_v_q    <= 1'b0;
      pend_addr_q <= '0;
      pend_data_q <= '0;
    end else if (wr_req && (blk_i || pend_v_q)) begin
      pend_v_q    <= 1'b1;
      pend_addr_q <= addr_i;
      pend_data_q <= wdata_i;
    end else if (!blk_i && pend_v_q) begin
      pend_v_q    <= 1'b0;
    end
  end

  AST_PEND_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blk_i && pend_v_q) |=> pend_v_q); // R5
endmodule

// File: rtl/twin_port_ram_mem.sv
module twin_port_ram_mem #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              l_we_i,
  input  logic [ADDR_W-1:0] l_waddr_i,
  input  logic [DATA_W-1:0] l_wdata_i,
  input  logic              r_we_i,
  input  logic [ADDR_W-1:0] r_waddr_i,
  input  logic [DATA_W-1:0] r_wdata_i,
  input  logic              l_re_i,
  input  logic [ADDR_W-1:0] l_raddr_i,
  input  logic              r_re_i,
  input  logic [ADDR_W-1:0] r_raddr_i,
  output logic [DATA_W-1:0] l_rdata_o,
  output logic [DATA_W-1:0] r_rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  // right first, so left data survives a same-word double write
  always_ff @(posedge clk_i) begin
    if (r_we_i) mem_q[r_waddr_i] <= r_wdata_i;
    if (l_we_i) mem_q[l_waddr_i] <= l_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      l_rdata_o <= '0;
      r_rdata_o <= '0;
    end else begin
      if (l_re_i) l_rdata_o <= mem_q[l_raddr_i];
      if (r_re_i) r_rdata_o <= mem_q[r_raddr_i];
    end
  end
endmodule

// File: rtl/twin_port_ram.sv
module twin_port_ram
  import twin_port_ram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              master_i,
  input  logic              l_en_i,
  input  logic              l_we_i,
  input  logic              l_oe_i,
  input  logic [ADDR_W-1:0] l_addr_i,
  input  logic [DATA_W-1:0] l_wdata_i,
  input  logic              l_busy_i,
  output logic [DATA_W-1:0] l_rdata_o,
  output logic              l_busy_o,
  input  logic              r_en_i,
  input  logic              r_we_i,
  input  logic              r_oe_i,
  input  logic [ADDR_W-1:0] r_addr_i,
  input  logic [DATA_W-1:0] r_wdata_i,
  input  logic              r_busy_i,
  output logic [DATA_W-1:0] r_rdata_o,
  output logic              r_busy_o
);
  logic              l_blk, r_blk;
  logic              l_mwe, r_mwe;
  logic [ADDR_W-1:0] l_maddr, r_maddr;
  logic [DATA_W-1:0] l_mdata, r_mdata;
  logic [DATA_W-1:0] l_rq, r_rq;

  twin_port_ram_arb #(.ADDR_W(ADDR_W)) u_arb (
    .clk_i, .rst_ni, .master_i,
    .l_en_i, .l_we_i, .l_addr_i, .l_busy_ext_i(l_busy_i),
    .r_en_i, .r_we_i, .r_addr_i, .r_busy_ext_i(r_busy_i),
    .l_blk_o(l_blk), .r_blk_o(r_blk)
  );

  twin_port_ram_wq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wq_l (
    .clk_i, .rst_ni, .en_i(l_en_i), .we_i(l_we_i), .addr_i(l_addr_i),
    .wdata_i(l_wdata_i), .blk_i(l_blk),
    .mem_we_o(l_mwe), .mem_addr_o(l_maddr), .mem_data_o(l_mdata)
  );

  twin_port_ram_wq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wq_r (
    .clk_i, .rst_ni, .en_i(r_en_i), .we_i(r_we_i), .addr_i(r_addr_i),
    .wdata_i(r_wdata_i), .blk_i(r_blk),
    .mem_we_o(r_mwe), .mem_addr_o(r_maddr), .mem_data_o(r_mdata)
  );

  twin_port_ram_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk_i, .rst_ni,
    .l_we_i(l_mwe), .l_waddr_i(l_maddr), .l_wdata_i(l_mdata),
    .r_we_i(r_mwe), .r_waddr_i(r_maddr), .r_wdata_i(r_mdata),
    .l_re_i(l_en_i && !l_we_i), .l_raddr_i(l_addr_i),
    .r_re_i(r_en_i && !r_we_i), .r_raddr_i(r_addr_i),
    .l_rdata_o(l_rq), .r_rdata_o(r_rq)
  );

  assign l_busy_o  = l_blk;
  assign r_busy_o  = r_blk;
  assign l_rdata_o = l_oe_i ? l_rq : '0;
  assign r_rdata_o = r_oe_i ? r_rq : '0;

  AST_L_NO_WR_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    l_busy_o |-> !l_mwe); // R5
  AST_R_NO_WR_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    r_busy_o |-> !r_mwe); // R5
  AST_SLAVE_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!master_i && l_busy_i) |-> !l_mwe); // R6
endmodule

// File: tb/twin_port_ram_tb_top.sv
module twin_port_ram_tb_top;
  localparam int AW = 8;
  localparam int DW = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic master;
  logic l_en, l_we, l_oe, l_bi, r_en, r_we, r_oe, r_bi;
  logic [AW-1:0] l_addr, r_addr;
  logic [DW-1:0] l_wd, r_wd;
  logic [DW-1:0] l_rd, r_rd;
  logic l_bo, r_bo;
  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  twin_port_ram #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .master_i(master),
    .l_en_i(l_en), .l_we_i(l_we), .l_oe_i(l_oe), .l_addr_i(l_addr),
    .l_wdata_i(l_wd), .l_busy_i(l_bi), .l_rdata_o(l_rd), .l_busy_o(l_bo),
    .r_en_i(r_en), .r_we_i(r_we), .r_oe_i(r_oe), .r_addr_i(r_addr),
    .r_wdata_i(r_wd), .r_busy_i(r_bi), .r_rdata_o(r_rd), .r_busy_o(r_bo)
  );

  typedef struct packed {
    logic          le;
    logic          lw;
    logic [AW-1:0] la;
    logic [DW-1:0] ld;
    logic          re;
    logic          rw;
    logic [AW-1:0] ra;
    logic [DW-1:0] rdv;
    logic          xbl;
    logic          xbr;
  } vec_t;

  // master mode busy sequence; history matters from row to row
  localparam vec_t VECS [9] = '{
    '{1'b1, 1'b1, 8'd5, 9'h0A5, 1'b0, 1'b0, 8'd0, 9'h000, 1'b0, 1'b0}, // R1
    '{1'b1, 1'b0, 8'd5, 9'h000, 1'b1, 1'b0, 8'd5, 9'h000, 1'b0, 1'b0}, // R7
    '{1'b1, 1'b1, 8'd7, 9'h011, 1'b1, 1'b1, 8'd7, 9'h022, 1'b0, 1'b1}, // R3
    '{1'b1, 1'b1, 8'd7, 9'h011, 1'b1, 1'b1, 8'd7, 9'h022, 1'b0, 1'b1}, // R2
    '{1'b1, 1'b1, 8'd7, 9'h011, 1'b1, 1'b1, 8'd8, 9'h033, 1'b0, 1'b0}, // R4
    '{1'b1, 1'b0, 8'd8, 9'h000, 1'b1, 1'b1, 8'd8, 9'h033, 1'b1, 1'b0}, // R10
    '{1'b0, 1'b0, 8'd8, 9'h000, 1'b1, 1'b1, 8'd8, 9'h033, 1'b0, 1'b0}, // R4
    '{1'b1, 1'b0, 8'd9, 9'h000, 1'b1, 1'b1, 8'd9, 9'h044, 1'b0, 1'b1}, // R3
    '{1'b1, 1'b0, 8'd9, 9'h000, 1'b1, 1'b1, 8'd9, 9'h044, 1'b0, 1'b1}  // R2
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    l_en = 0; l_we = 0; l_addr = '0; l_wd = '0;
    r_en = 0; r_we = 0; r_addr = '0; r_wd = '0;
  endtask

  task automatic set_l(input logic e, input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d);
    l_en = e; l_we = w; l_addr = a; l_wd = d;
  endtask

  task automatic set_r(input logic e, input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d);
    r_en = e; r_we = w; r_addr = a; r_wd = d;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; idle();
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=running expected=done");
    finish_run();
  end

  initial begin
    master = 1; l_oe = 1; r_oe = 1; l_bi = 0; r_bi = 0;
    idle();
    do_reset();
    #1;
    chk("R1 reset l_busy", l_bo, 0);
    chk("R1 reset r_busy", r_bo, 0);
    chk("R1 reset l_rdata", l_rd, 0);
    chk("R1 reset r_rdata", r_rd, 0);

    for (int i = 0; i < 9; i++) begin
      @(negedge clk);
      set_l(VECS[i].le, VECS[i].lw, VECS[i].la, VECS[i].ld);
      set_r(VECS[i].re, VECS[i].rw, VECS[i].ra, VECS[i].rdv);
      #1;
      chk($sformatf("R2 vec%0d l_busy", i), l_bo, VECS[i].xbl);
      chk($sformatf("R2 vec%0d r_busy", i), r_bo, VECS[i].xbr);
    end

    do_reset();
    // R1 write then read on the other port
    set_l(1, 1, 8'd3, 9'h1A5);
    @(negedge clk); idle(); set_r(1, 0, 8'd3, 0);
    @(negedge clk); idle(); #1;
    chk("R1 read after write", r_rd, 9'h1A5);
    r_oe = 0; #1;
    chk("R8 oe low gives zero", r_rd, 0);
    r_oe = 1; #1;
    chk("R8 held word returns", r_rd, 9'h1A5);

    // R9 read-before-write on a collision
    @(negedge clk); set_l(1, 1, 8'd4, 9'h055);
    @(negedge clk); set_l(1, 1, 8'd4, 9'h0AA); set_r(1, 0, 8'd4, 0); #1;
    chk("R3 left keeps word vs read", r_bo, 1);
    @(negedge clk); set_l(0, 0, 0, 0); #1;
    chk("R9 old data on same-cycle read", r_rd, 9'h055);
    @(negedge clk); idle(); #1;
    chk("R9 new data on next read", r_rd, 9'h0AA);

    // R5 / R11 blocked write held, replaced, drained
    @(negedge clk); set_l(1, 1, 8'd5, 9'h100);
    @(negedge clk); set_r(1, 1, 8'd5, 9'h0FF); #1;
    chk("R2 first arrival left wins", r_bo, 1);
    @(negedge clk); set_r(1, 1, 8'd5, 9'h0EE); #1;
    chk("R2 busy held", r_bo, 1);
    @(negedge clk); set_l(1, 0, 8'd5, 0); set_r(1, 1, 8'd6, 9'h033); #1;
    chk("R4 busy drops with match", r_bo, 0);
    @(negedge clk); set_r(0, 0, 0, 0); #1;
    chk("R5 no write while busy", l_rd, 9'h100);
    @(negedge clk); set_l(1, 0, 8'd6, 0); #1;
    chk("R5 latest pending committed", l_rd, 9'h0EE);
    @(negedge clk); idle(); #1;
    chk("R11 queued write committed", l_rd, 9'h033);

    // R10 right arrives first
    @(negedge clk); set_r(1, 1, 8'd7, 9'h1FF);
    @(negedge clk); set_l(1, 1, 8'd7, 9'h000); #1;
    chk("R10 left busy", l_bo, 1);
    chk("R10 right free", r_bo, 0);
    @(negedge clk); idle(); #1;
    chk("R4 busy drops when idle", l_bo, 0);
    @(negedge clk); set_r(1, 0, 8'd7, 0);
    @(negedge clk); idle(); #1;
    chk("R10 left pending committed", r_rd, 9'h000);

    // R7 shared read
    @(negedge clk); set_l(1, 0, 8'd9, 0); set_r(1, 0, 8'd9, 0); #1;
    chk("R7 reads no l_busy", l_bo, 0);
    chk("R7 reads no r_busy", r_bo, 0);

    // R6 slave mode
    @(negedge clk); master = 0; set_l(1, 1, 8'd10, 9'h111); set_r(1, 1, 8'd10, 9'h122); #1;
    chk("R6 no internal busy l", l_bo, 0);
    chk("R6 no internal busy r", r_bo, 0);
    @(negedge clk); set_l(1, 0, 8'd10, 0); set_r(1, 1, 8'd11, 9'h000);
    @(negedge clk); #1;
    chk("R6 left data kept", l_rd, 9'h111);
    l_bi = 1; set_l(1, 1, 8'd11, 9'h1C3); set_r(0, 0, 0, 0); #1;
    chk("R6 busy follows input", l_bo, 1);
    @(negedge clk); set_l(0, 0, 0, 0); set_r(1, 0, 8'd11, 0);
    @(negedge clk); #1;
    chk("R6 external busy blocks write", r_rd, 9'h000);
    l_bi = 0; set_r(0, 0, 0, 0); #1;
    chk("R6 busy released", l_bo, 0);
    @(negedge clk); set_r(1, 0, 8'd11, 0);
    @(negedge clk); idle(); #1;
    chk("R6 pending lands after release", r_rd, 9'h1C3);

    finish_run();
  end
endmodule